// File: doc/BRIEF.md
# Big-Endian Load-Store Byte Lane Unit

This unit sits between a 32-bit processor datapath and a data memory that is addressed only by whole words. A store request carries a byte address, a register value and an access size. In the same cycle the unit produces three outputs for the memory: a word-aligned address, four per-lane write enables and write data steered onto the lanes. A load request drives the same aligned address. One clock later, the memory returns a word. The unit picks the addressed byte or halfword out of that word and widens it to 32 bits, filling the upper bits with zeros or with copies of the sign bit.

Lanes are numbered big-endian. Byte offset 0 within a word is bits 31:24, and offset 3 is bits 7:0. A halfword access needs an even address. A word access needs an address that is a multiple of four. Any access that breaks this rule raises a one-cycle fault. A misaligned store writes nothing. A misaligned load returns a response with the register write suppressed.

Top module: `lsu_lane_steer`

## Requirements
- R1: `mem_addr` always equals `req_addr` with bits 1:0 forced to zero.
- R2: The size codes are 00 for byte, 01 for halfword and 10 or 11 for word. A request is misaligned in two cases: it is a halfword with address bit 0 set, or it is a word with either of address bits 1:0 set. `fault` is high during the clock cycle after a misaligned request and low after any other cycle.
- R3: A misaligned store drives `mem_we` to 0000. A misaligned load still produces `rsp_valid`, but with `rsp_wen` low and `rsp_data` zero.
- R4: For an aligned store, `mem_we` has the following values:
  - byte: bit (3 − offset) set, where `mem_we[3]` enables bits 31:24 and `mem_we[0]` enables bits 7:0;
  - halfword at offset 0: 1100;
  - halfword at offset 2: 0011;
  - word: 1111.
  
  `mem_we` is 0000 whenever no store is requested.
- R5: For a store, `mem_wdata` carries the low byte of `req_wdata` in all four lanes for a byte access. It carries the low halfword in both halves for a halfword access, and all of `req_wdata` for a word access.
- R6: A load request accepted at a clock edge raises `rsp_valid` for exactly the following cycle. During that cycle `rsp_data` is formed from the `mem_rdata` presented in that same cycle. Stores do not raise `rsp_valid`.
- R7: An aligned load selects lanes big-endian, using the offset and size captured with the request. A byte load takes bits 31−8·offset down to 24−8·offset. A halfword load takes bits 31:16 at offset 0 and bits 15:0 at offset 2.
- R8: When `req_unsigned` is 0, a byte or halfword load fills bits 31 down to the field width with the field's top bit. When it is 1, they are filled with zeros. A word load returns all 32 bits unchanged for either value.
- R9: When synchronous reset `rst` is high at a clock edge, `rsp_valid`, `rsp_wen` and `fault` are low afterwards, even if a request was present.
- R10: Size code 11 behaves exactly as a word access in steering, alignment and extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_unsigned | input | 1 | Zero-extend narrow loads when 1 |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store source register value |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_we | output | 4 | Per-lane write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Word returned by memory the cycle after a load |
| rsp_valid | output | 1 | Load response cycle |
| rsp_wen | output | 1 | Destination register write enable |
| rsp_data | output | 32 | Extended load result |
| fault | output | 1 | Misaligned access seen in the previous cycle |

## Verification
Random requests draw the size code, the signedness, the address and the data independently. This covers every offset against every size, including the spare word code. Aligned and misaligned cases are therefore mixed in the same run, and lane order is tested against both halves of the word. Returned words have random top bits, so zero fill and sign fill give different results; a sign bit that is always 0 would hide that difference. Directed cases cover the remaining situations:
- a signed byte of 0x80 at every offset;
- halfwords of 0x8000 and 0x7FFF at both offsets;
- misaligned word and halfword stores followed by an idle cycle, to confirm that the fault falls after one cycle;
- a load that arrives while reset is held.

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic          req_unsigned,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_we,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          rsp_valid,
  output logic          rsp_wen,
  output logic [31:0]   rsp_data,
  output logic          fault
);

  logic [1:0] off;
  logic       sz_byte, sz_half, sz_word, misal;
  logic [3:0] lanes;

  assign off     = req_addr[1:0];
  assign sz_byte = (req_size == 2'b00);
  assign sz_half = (req_size == 2'b01);
  assign sz_word = req_size[1];
  assign misal   = (sz_half & off[0]) | (sz_word & (off != 2'b00));

  assign mem_addr = {req_addr[AW-1:2], 2'b00};

  always_comb begin
    if (sz_byte)      lanes = 4'b1000 >> off;
    else if (sz_half) lanes = off[1] ? 4'b0011 : 4'b1100;
    else              lanes = 4'b1111;
  end

  assign mem_we = (req_valid & req_write & ~misal) ? lanes : 4'b0000;

  always_comb begin
    if (sz_byte)      mem_wdata = {4{req_wdata[7:0]}};
    else if (sz_half) mem_wdata = {2{req_wdata[15:0]}};
    else              mem_wdata = req_wdata;
  end

  logic [1:0] q_off;
  logic [1:0] q_size;
  logic       q_uns;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_wen   <= 1'b0;
      fault     <= 1'b0;
      q_off     <= 2'b00;
      q_size    <= 2'b00;
      q_uns     <= 1'b0;
    end else begin
      rsp_valid <= req_valid & ~req_write;
      rsp_wen   <= req_valid & ~req_write & ~misal;
      fault     <= req_valid & misal;
      if (req_valid & ~req_write) begin
        q_off  <= off;
        q_size <= req_size;
        q_uns  <= req_unsigned;
      end
    end
  end

  logic [7:0]  b_sel;
  logic [15:0] h_sel;
  logic [31:0] ext;

  always_comb begin
    case (q_off)
      2'd0:    b_sel = mem_rdata[31:24];
      2'd1:    b_sel = mem_rdata[23:16];
      2'd2:    b_sel = mem_rdata[15:8];
      default: b_sel = mem_rdata[7:0];
    endcase
  end

  assign h_sel = q_off[1] ? mem_rdata[15:0] : mem_rdata[31:16];

  always_comb begin
    if (q_size == 2'b00)      ext = {{24{~q_uns & b_sel[7]}}, b_sel};
    else if (q_size == 2'b01) ext = {{16{~q_uns & h_sel[15]}}, h_sel};
    else                      ext = mem_rdata;
  end

  assign rsp_data = rsp_wen ? ext : 32'h0;

endmodule

// File: rtl/lsu_lane_steer_chk.sv
module lsu_lane_steer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_write,
  input logic [1:0]    req_size,
  input logic [AW-1:0] req_addr,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_we,
  input logic          rsp_valid,
  input logic          rsp_wen,
  input logic          fault
);
  logic bad;
  assign bad = (req_size == 2'b01 && req_addr[0]) || (req_size[1] && req_addr[1:0] != 2'b00);

  p_addr_word_r1: assert property (@(posedge clk)
    mem_addr[1:0] == 2'b00 && mem_addr[AW-1:2] == req_addr[AW-1:2]);

  p_fault_set_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && bad |=> fault);

  p_fault_clear_r2: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && bad) |=> !fault);

  p_no_write_misal_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_write && bad |-> mem_we == 4'b0000);

  p_wen_needs_ok_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_wen |-> rsp_valid && !fault);

  p_idle_no_we_r4: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |-> mem_we == 4'b0000);

  p_load_rsp_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write |=> rsp_valid);

  p_store_no_rsp_r6: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind lsu_lane_steer lsu_lane_steer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .req_addr(req_addr), .mem_addr(mem_addr),
  .mem_we(mem_we), .rsp_valid(rsp_valid), .rsp_wen(rsp_wen), .fault(fault)
);

// File: tb/sim_lsu_lane_steer.sv
module sim_lsu_lane_steer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_addr = '0, req_wdata = '0, mem_rdata = '0;
  logic [31:0] mem_addr, mem_wdata, rsp_data;
  logic [3:0]  mem_we;
  logic        rsp_valid, rsp_wen, fault;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lsu_lane_steer u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
    .req_wdata(req_wdata), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_wen(rsp_wen), .rsp_data(rsp_data), .fault(fault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit e_mis(input logic [1:0] sz, input logic [1:0] o);
    if (sz == 2'b01) return o[0];
    if (sz[1]) return o != 2'b00;
    return 1'b0;
  endfunction

  function automatic logic [3:0] e_lanes(input logic [1:0] sz, input logic [1:0] o);
    if (sz == 2'b00) return 4'b1000 >> o;
    if (sz == 2'b01) return o[1] ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] e_wdata(input logic [1:0] sz, input logic [31:0] d);
    if (sz == 2'b00) return {d[7:0], d[7:0], d[7:0], d[7:0]};
    if (sz == 2'b01) return {d[15:0], d[15:0]};
    return d;
  endfunction

  function automatic logic [31:0] e_load(input logic [1:0] sz, input logic [1:0] o,
                                         input logic u, input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[31 - 8*o -: 8];
    h = o[1] ? w[15:0] : w[31:16];
    if (sz == 2'b00) return u ? {24'h0, b} : {{24{b[7]}}, b};
    if (sz == 2'b01) return u ? {16'h0, h} : {{16{h[15]}}, h};
    return w;
  endfunction

  task automatic do_op(input logic wr, input logic [1:0] sz, input logic u,
                       input logic [31:0] a, input logic [31:0] d, input logic [31:0] rd);
    bit m;
    m = e_mis(sz, a[1:0]);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_unsigned = u;
    req_addr = a; req_wdata = d;
    #1;
    chk("R1 mem_addr", mem_addr, {a[31:2], 2'b00});
    if (wr) begin
      chk(m ? "R3 misaligned store we" : "R4 lane enables",
          {28'h0, mem_we}, m ? 32'h0 : {28'h0, e_lanes(sz, a[1:0])});
      chk(sz[1] ? "R5/R10 word wdata" : "R5 wdata", mem_wdata, e_wdata(sz, d));
    end else begin
      chk("R4 load no write", {28'h0, mem_we}, 32'h0);
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    mem_rdata = rd;
    #1;
    chk("R2 fault", {31'h0, fault}, {31'h0, m});
    chk("R6 rsp_valid", {31'h0, rsp_valid}, {31'h0, ~wr});
    if (!wr) begin
      chk("R3 rsp_wen", {31'h0, rsp_wen}, {31'h0, ~m});
      chk(m ? "R3 misaligned data" : (sz[1] ? "R7/R8/R10 load" : "R7/R8 load"),
          rsp_data, m ? 32'h0 : e_load(sz, a[1:0], u, rd));
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #2;
    chk("R2 fault one cycle", {31'h0, fault}, 32'h0);
    chk("R6 valid one cycle", {31'h0, rsp_valid}, 32'h0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    chk("R9 reset valid", {31'h0, rsp_valid}, 32'h0);
    chk("R9 reset fault", {31'h0, fault}, 32'h0);
    chk("R9 reset wen", {31'h0, rsp_wen}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int o = 0; o < 4; o++) begin
      do_op(1'b0, 2'b00, 1'b0, 32'h1000 + o, 0, 32'h80808080);
      do_op(1'b0, 2'b00, 1'b1, 32'h1000 + o, 0, 32'h80808080);
    end
    do_op(1'b0, 2'b01, 1'b0, 32'h2000, 0, 32'h80007FFF);
    do_op(1'b0, 2'b01, 1'b0, 32'h2002, 0, 32'h80007FFF);
    do_op(1'b0, 2'b01, 1'b1, 32'h2000, 0, 32'h80007FFF);
    do_op(1'b0, 2'b11, 1'b0, 32'h3000, 0, 32'hDEADBEEF);
    do_op(1'b1, 2'b10, 1'b0, 32'h4002, 32'h12345678, 0);
    idle_check();
    do_op(1'b1, 2'b01, 1'b0, 32'h4001, 32'h12345678, 0);
    idle_check();
    do_op(1'b0, 2'b11, 1'b0, 32'h4003, 0, 32'hFFFFFFFF);
    idle_check();
    for (int o = 0; o < 4; o++) do_op(1'b1, 2'b00, 1'b0, 32'h5000 + o, 32'hA5, 0);
    do_op(1'b1, 2'b01, 1'b0, 32'h5002, 32'hBEEF, 0);

    @(negedge clk);
    rst = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_size = 2'b01; req_addr = 32'h7;
    @(posedge clk);
    #2;
    chk("R9 reset over request valid", {31'h0, rsp_valid}, 32'h0);
    chk("R9 reset over request fault", {31'h0, fault}, 32'h0);
    @(negedge clk);
    rst = 1'b0; req_valid = 1'b0;

    for (int i = 0; i < 400; i++) begin
      do_op(1'($urandom), 2'($urandom), 1'($urandom), $urandom, $urandom, $urandom);
      if ($urandom % 8 == 0) idle_check();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule